// File: doc/BRIEF.md
# Edge Timestamp Capture Unit

The block records when an external signal changes. On each qualifying edge of an already-synchronised input, it copies the value of a free-running timer into a four-entry first-in first-out buffer. Software reads the buffer one entry at a time. A 16-bit control word sets up the capture. It selects which edges count, how many rising edges make up one capture, and how many captures raise one interrupt pulse. It also selects which of two 16-bit timer buses is sampled, or both buses joined into one 32-bit stamp.

The control word is reached through a small register bus. The word can be written whole. It can also be changed through three alias addresses that clear, set or invert only the bits written as one. Two read-only status bits show whether the buffer holds data and whether a capture was lost. A freeze input can stop capture while a debugger holds the system, but only when a control bit allows it.

Top module: `ecap_top`

## Requirements
- R1: Control bits [2:0] select the capture mode. Code 1 captures on every edge, code 2 on every falling edge and code 3 on every rising edge. Code 0 captures nothing.
- R2: Code 4 captures on every 4th rising edge and code 5 on every 16th. The first capture comes on the 4th (or 16th) rising edge after the unit is enabled.
- R3: Code 6 makes its first capture on the edge chosen by bit 9 (1 = rising, 0 = falling). After that first capture it captures on every edge.
- R4: Code 7 raises the interrupt once for each rising edge, whatever bits [6:5] hold. Nothing enters the buffer in this mode.
- R5: Bits [6:5] hold a code n from 0 to 3. The interrupt pulses once per n+1 capture events, counting also the captures that are lost to overflow. The pulse lasts one cycle and appears in the cycle after the clock edge that samples the input edge.
- R6: The buffer holds four entries. A read of address 0x10 returns the oldest entry and removes it. A read of address 0x10 on an empty buffer returns the most recently removed value and changes nothing. If a read and a capture fall on the same cycle while the buffer is full, the capture is still accepted.
- R7: Read-only bit 3 is 1 while the buffer holds an entry. Read-only bit 4 becomes 1 when a capture finds the buffer full; that capture is dropped. Bit 4 then stays 1 until the unit is cleared (R10). Writes to bits 3 and 4 have no effect.
- R8: When bit 8 is 0, the stamp is the timer that bit 7 selects (0 = tmr_a, 1 = tmr_b), zero-extended to 32 bits. When bit 8 is 1, the stamp is {tmr_b, tmr_a}.
- R9: Bit 15 enables the unit. When bit 14 is 1 and freeze_in is high, input edges are ignored and all counters hold their values.
- R10: While bit 15 is 0 or the mode is 0, the buffer, the overflow flag, the prescale count, the interrupt count and the first-edge state are all reset.
- R11: The writable control bits are [15:14], [9:5] and [2:0]. A write to 0x0 loads the whole word. Writes to 0x4, 0x8 and 0xC clear, set or invert the bits written as one. A read of 0x0 returns the word with the status bits included. Reads of any other address return 0.
- R12: After reset the control word is 0, rd_data is 0 and irq_pulse is low. Read data appears on rd_data in the cycle after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cap_pin | input | 1 | Capture input, already synchronised |
| freeze_in | input | 1 | Debug freeze request |
| tmr_a | input | 16 | First timer count |
| tmr_b | input | 16 | Second timer count; upper half of a 32-bit stamp |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 5 | Register byte address |
| bus_wdata | input | 16 | Write data |
| rd_data | output | 32 | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt pulse |

## Verification
The assertions assume that reads and writes are single-cycle strobes, that cap_pin changes only away from the clock edge, and that each read of address 0x10 counts as one removal. The bench drives all inputs just after the falling clock edge. It holds each level of cap_pin for at least two cycles, so the unit sees every edge. It moves the unit through mode 0 whenever it changes mode, so the prescale count never carries over from one mode into the next. Both timer buses advance every cycle in a fixed relation to each other, so a stamp shows which bus was sampled and in which cycle.

// File: rtl/ecap_pkg.sv
// Shared encodings for the edge timestamp capture unit: mode codes,
// control bit positions, writable mask and register addresses.
package ecap_pkg;
    typedef enum logic [2:0] {
        M_OFF     = 3'd0,
        M_BOTH    = 3'd1,
        M_FALL    = 3'd2,
        M_RISE    = 3'd3,
        M_DIV4    = 3'd4,
        M_DIV16   = 3'd5,
        M_FIRST   = 3'd6,
        M_IRQONLY = 3'd7
    } cap_mode_e;

    localparam int CTRL_W  = 16;
    localparam int ADDR_W  = 5;
    localparam int B_NE    = 3;
    localparam int B_OV    = 4;
    localparam int B_TSEL  = 7;
    localparam int B_WIDE  = 8;
    localparam int B_FRISE = 9;
    localparam int B_FRZ   = 14;
    localparam int B_ON    = 15;

    localparam logic [CTRL_W-1:0] CTRL_WMASK = 16'hC3E7;

    localparam logic [ADDR_W-1:0] A_CTRL = 5'h00;
    localparam logic [ADDR_W-1:0] A_CLR  = 5'h04;
    localparam logic [ADDR_W-1:0] A_SET  = 5'h08;
    localparam logic [ADDR_W-1:0] A_INV  = 5'h0C;
    localparam logic [ADDR_W-1:0] A_BUF  = 5'h10;
endpackage

// File: rtl/ecap_edge_sel.sv
// Edge qualifier: finds rising and falling edges on the capture input and
// turns them into capture events according to the mode, including the
// rising-edge prescaler and the first-edge state of mode 6.
// Assumes pin is synchronised already; clear and active come from the
// registered control word.
module ecap_edge_sel
    import ecap_pkg::*;
#(
    parameter int PRE_SHORT = 4,
    parameter int PRE_LONG  = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      clear,
    input  logic      active,
    input  cap_mode_e mode,
    input  logic      first_rise,
    input  logic      pin,
    output logic      cap_evt,
    output logic      bare_evt
);
    localparam int PW = $clog2(PRE_LONG);

    logic          pin_q;
    logic [PW-1:0] pre_q;
    logic          first_done_q;
    logic          rise, fall, pre_hit, prescaled;
    logic [PW-1:0] pre_lim;

    assign rise      = pin & ~pin_q;
    assign fall      = ~pin & pin_q;
    assign prescaled = (mode == M_DIV4) || (mode == M_DIV16);
    assign pre_lim   = (mode == M_DIV4) ? PW'(PRE_SHORT - 1) : PW'(PRE_LONG - 1);
    assign pre_hit   = rise && (pre_q >= pre_lim);

    // Decode the mode into a capture event or an interrupt-only event.
    always_comb begin
        cap_evt  = 1'b0;
        bare_evt = 1'b0;
        if (active && !clear) begin
            case (mode)
                M_BOTH:    cap_evt = rise | fall;
                M_FALL:    cap_evt = fall;
                M_RISE:    cap_evt = rise;
                M_DIV4,
                M_DIV16:   cap_evt = pre_hit;
                M_FIRST:   cap_evt = first_done_q ? (rise | fall)
                                                  : (first_rise ? rise : fall);
                M_IRQONLY: bare_evt = rise;
                default:   cap_evt = 1'b0;
            endcase
        end
    end

    // Keep the previous pin level so that edges can be found.
    always_ff @(posedge clk) begin
        if (!rst_n) pin_q <= 1'b0;
        else        pin_q <= pin;
    end

    // Count rising edges in the prescaled modes.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                 pre_q <= '0;
        else if (active && prescaled && rise) pre_q <= pre_hit ? '0 : pre_q + 1'b1;
    end

    // Record that mode 6 has made its first capture.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)                       first_done_q <= 1'b0;
        else if (mode == M_FIRST && cap_evt)       first_done_q <= 1'b1;
    end
endmodule

// File: rtl/ecap_fifo.sv
// Small capture buffer. A push is accepted when there is space or when a
// pop happens in the same cycle. A pop on an empty buffer is ignored.
// Flush empties the buffer. Assumes DEPTH >= 2.
module ecap_fifo #(
    parameter int DEPTH = 4,
    parameter int W     = 32,
    localparam int AW   = $clog2(DEPTH),
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic          pop,
    input  logic [W-1:0]  din,
    output logic [W-1:0]  dout,
    output logic [FW-1:0] fill,
    output logic          full
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_pop, do_push;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (fill == FW'(DEPTH));
    assign do_pop  = pop && (fill != '0);
    assign do_push = push && (!full || do_pop);
    assign dout    = mem[rp];

    // Store the incoming stamp.
    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    // Move the pointers and the fill count.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            wp   <= '0;
            rp   <= '0;
            fill <= '0;
        end else begin
            if (do_push) wp <= bump(wp);
            if (do_pop)  rp <= bump(rp);
            fill <= fill + FW'(do_push) - FW'(do_pop);
        end
    end
endmodule

// File: rtl/ecap_irq_div.sv
// Interrupt rate divider: gives one registered pulse for each rate+1
// capture events. A direct request, used in interrupt-only mode, pulses
// on every event.
module ecap_irq_div #(
    parameter int RW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          evt,
    input  logic          direct,
    input  logic [RW-1:0] rate,
    output logic          irq
);
    logic [RW-1:0] cnt_q;
    logic          hit;

    assign hit = evt && (cnt_q >= rate);

    // Count capture events until the chosen rate is reached.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt_q <= '0;
        else if (evt)        cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end

    // Register the interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= !clear && (direct || hit);
    end
endmodule

// File: rtl/ecap_top.sv
// Edge timestamp capture unit top: control word and its aliases, status,
// stamp selection, overflow tracking and registered read data.
// Assumes single-cycle bus strobes and a synchronised capture input.
module ecap_top
    import ecap_pkg::*;
#(
    parameter int TMR_W = 16,
    parameter int DEPTH = 4,
    localparam int DW   = 2 * TMR_W,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_pin,
    input  logic              freeze_in,
    input  logic [TMR_W-1:0]  tmr_a,
    input  logic [TMR_W-1:0]  tmr_b,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CTRL_W-1:0] bus_wdata,
    output logic [DW-1:0]     rd_data,
    output logic              irq_pulse
);
    logic [CTRL_W-1:0] ctrl_q, wmask, ctrl_view;
    logic              ovf_q, active, clear, pop, cap_evt, bare_evt, full;
    logic [DW-1:0]     stamp, head, last_q;
    logic [FW-1:0]     fill;
    cap_mode_e         mode;

    assign mode   = cap_mode_e'(ctrl_q[2:0]);
    assign active = ctrl_q[B_ON] && !(ctrl_q[B_FRZ] && freeze_in);
    assign clear  = !ctrl_q[B_ON] || (mode == M_OFF);
    assign pop    = bus_rd && (bus_addr == A_BUF);
    assign wmask  = bus_wdata & CTRL_WMASK;
    assign stamp  = ctrl_q[B_WIDE] ? {tmr_b, tmr_a}
                                   : {{TMR_W{1'b0}}, (ctrl_q[B_TSEL] ? tmr_b : tmr_a)};

    // Show the control word with the live status bits.
    always_comb begin
        ctrl_view        = ctrl_q;
        ctrl_view[B_NE]  = (fill != '0);
        ctrl_view[B_OV]  = ovf_q;
    end

    ecap_edge_sel u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .active    (active),
        .mode      (mode),
        .first_rise(ctrl_q[B_FRISE]),
        .pin       (cap_pin),
        .cap_evt   (cap_evt),
        .bare_evt  (bare_evt)
    );

    ecap_fifo #(.DEPTH(DEPTH), .W(DW)) u_fifo (
        .clk  (clk),
        .rst_n(rst_n),
        .flush(clear),
        .push (cap_evt),
        .pop  (pop),
        .din  (stamp),
        .dout (head),
        .fill (fill),
        .full (full)
    );

    ecap_irq_div #(.RW(2)) u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (clear),
        .evt   (cap_evt),
        .direct(bare_evt),
        .rate  (ctrl_q[6:5]),
        .irq   (irq_pulse)
    );

    // Apply whole-word and clear/set/invert alias writes.
    always_ff @(posedge clk) begin
        if (!rst_n) ctrl_q <= '0;
        else if (bus_wr) begin
            case (bus_addr)
                A_CTRL:  ctrl_q <= wmask;
                A_CLR:   ctrl_q <= ctrl_q & ~wmask;
                A_SET:   ctrl_q <= ctrl_q | wmask;
                A_INV:   ctrl_q <= ctrl_q ^ wmask;
                default: ctrl_q <= ctrl_q;
            endcase
        end
    end

    // Keep the overflow flag until the unit is cleared.
    always_ff @(posedge clk) begin
        if (!rst_n || clear)               ovf_q <= 1'b0;
        else if (cap_evt && full && !pop)  ovf_q <= 1'b1;
    end

    // Keep the most recently removed stamp for reads of an empty buffer.
    always_ff @(posedge clk) begin
        if (!rst_n)                 last_q <= '0;
        else if (pop && fill != '0) last_q <= head;
    end

    // Register the read data.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_data <= '0;
        else if (bus_rd) begin
            case (bus_addr)
                A_CTRL:  rd_data <= DW'(ctrl_view);
                A_BUF:   rd_data <= (fill != '0) ? head : last_q;
                default: rd_data <= '0;
            endcase
        end
    end
endmodule

// File: rtl/ecap_chk.sv
// Property checker for the edge timestamp capture unit, bound to ecap_top.
module ecap_chk #(
    parameter int DEPTH = 4,
    localparam int FW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [15:0]   ctrl,
    input logic [FW-1:0] fill,
    input logic          ovf,
    input logic          clear,
    input logic          pop,
    input logic          freeze_in,
    input logic          irq_pulse
);
    // R6
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= FW'(DEPTH));

    // R7
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !clear) |=> ovf);

    // R4
    irqonly_nopush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && ctrl[2:0] == 3'd7 && !pop) |=> fill == $past(fill));

    // R9
    irq_needs_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(ctrl[15]));

    // R9
    frozen_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clear && ctrl[14] && freeze_in && !pop) |=> fill == $past(fill));

    // R10
    clear_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (fill == '0 && !ovf));
endmodule

bind ecap_top ecap_chk #(.DEPTH(DEPTH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ctrl     (ctrl_q),
    .fill     (fill),
    .ovf      (ovf_q),
    .clear    (clear),
    .pop      (pop),
    .freeze_in(freeze_in),
    .irq_pulse(irq_pulse)
);

// File: tb/ecap_top_test.sv
module ecap_top_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cap_pin = 1'b0;
    logic        freeze_in = 1'b0;
    logic [15:0] tmr_a, tmr_b;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [31:0] rd_data;
    logic        irq_pulse;

    int tests = 0;
    int fails = 0;
    int irq_cnt = 0;
    bit done = 0;
    logic [15:0] tick = '0;
    logic [15:0] rise_tick;

    always #5 clk = ~clk;

    always @(negedge clk) tick <= tick + 16'd1;
    assign tmr_a = tick;
    assign tmr_b = tick ^ 16'h5A5A;

    ecap_top uut (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .freeze_in(freeze_in),
        .tmr_a(tmr_a), .tmr_b(tmr_b), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .irq_pulse(irq_pulse)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [15:0] m_ctrl;
    logic        m_prev, m_first, m_ovf, exp_irq;
    int          m_pre, m_ev;
    logic [31:0] m_q[$];
    logic [31:0] m_last, exp_rd;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ctrl = 0; m_prev = 0; m_first = 0; m_ovf = 0; exp_irq = 0;
            m_pre = 0; m_ev = 0; m_q.delete(); m_last = 0; exp_rd = 0;
        end else begin
            bit rise, fall, en, clr, cap, irq;
            int mode, rate;
            logic [15:0] view;
            mode = int'(m_ctrl[2:0]);
            rate = int'(m_ctrl[6:5]);
            rise = cap_pin && !m_prev;
            fall = !cap_pin && m_prev;
            en   = m_ctrl[15] && !(m_ctrl[14] && freeze_in);
            clr  = !m_ctrl[15] || mode == 0;
            view = m_ctrl | (m_q.size() != 0 ? 16'h0008 : 16'h0) | (m_ovf ? 16'h0010 : 16'h0);
            if (bus_rd) begin
                if (bus_addr == 5'h00) exp_rd = {16'h0, view};
                else if (bus_addr == 5'h10) begin
                    if (m_q.size() > 0) m_last = m_q.pop_front();
                    exp_rd = m_last;
                end else exp_rd = 0;
            end
            cap = 0; irq = 0;
            if (clr) begin
                m_pre = 0; m_ev = 0; m_first = 0; m_ovf = 0; m_q.delete();
            end else if (en) begin
                case (mode)
                    1: cap = rise || fall;
                    2: cap = fall;
                    3: cap = rise;
                    4, 5: if (rise) begin
                        if (m_pre >= (mode == 4 ? 3 : 15)) begin cap = 1; m_pre = 0; end
                        else m_pre++;
                    end
                    6: if (m_first) cap = rise || fall;
                       else if (m_ctrl[9] ? rise : fall) begin cap = 1; m_first = 1; end
                    7: irq = rise;
                    default: ;
                endcase
                if (cap) begin
                    logic [31:0] stamp;
                    stamp = m_ctrl[8] ? {tmr_b, tmr_a} : {16'h0, (m_ctrl[7] ? tmr_b : tmr_a)};
                    if (m_q.size() < 4) m_q.push_back(stamp); else m_ovf = 1;
                    if (m_ev >= rate) begin irq = 1; m_ev = 0; end else m_ev++;
                end
            end
            exp_irq = irq;
            m_prev = cap_pin;
            if (bus_wr) begin
                case (bus_addr)
                    5'h00: m_ctrl = bus_wdata & 16'hC3E7;
                    5'h04: m_ctrl = m_ctrl & ~(bus_wdata & 16'hC3E7);
                    5'h08: m_ctrl = m_ctrl | (bus_wdata & 16'hC3E7);
                    5'h0C: m_ctrl = m_ctrl ^ (bus_wdata & 16'hC3E7);
                    default: ;
                endcase
            end
        end
    end

    // Compare against the model on every cycle and count interrupt pulses.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(irq_pulse === exp_irq, "R5 irq vs model", {31'b0, irq_pulse}, {31'b0, exp_irq});
            check(rd_data === exp_rd, "R11 rd_data vs model", rd_data, exp_rd);
            if (irq_pulse) irq_cnt++;
        end
    end

    // ---------------- stimulus tasks ----------------
    task automatic wr(input logic [4:0] a, input logic [15:0] d);
        @(negedge clk); #1;
        bus_wr = 1; bus_addr = a; bus_wdata = d;
        @(negedge clk); #1;
        bus_wr = 0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        @(negedge clk); #1;
        bus_rd = 1; bus_addr = a;
        @(negedge clk); #1;
        bus_rd = 0;
        v = rd_data;
    endtask

    task automatic pulse();
        @(negedge clk); #1; cap_pin = 1; rise_tick = tick;
        @(negedge clk); #1;
        @(negedge clk); #1; cap_pin = 0;
        @(negedge clk); #1;
    endtask

    task automatic pulses(input int n);
        for (int i = 0; i < n; i++) pulse();
    endtask

    task automatic drain(ref logic [31:0] q[$]);
        logic [31:0] s, v;
        q.delete();
        for (int i = 0; i < 8; i++) begin
            rd(5'h00, s);
            if (!s[3]) break;
            rd(5'h10, v);
            q.push_back(v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // ---------------- directed scenarios ----------------
    initial begin
        logic [31:0] v, s;
        logic [31:0] got[$];
        repeat (3) @(negedge clk);
        #1;
        check(rd_data == 0, "R12 reset rd_data", rd_data, 0);
        check(irq_pulse == 0, "R12 reset irq", {31'b0, irq_pulse}, 0);
        rst_n = 1;
        rd(5'h00, s);
        check(s == 0, "R12 reset control", s, 0);

        // R11 aliases and writable mask
        wr(5'h00, 16'hFFFF); rd(5'h00, s);
        check(s == 32'hC3E7, "R11 full write mask", s, 32'hC3E7);
        wr(5'h04, 16'h4000); rd(5'h00, s);
        check(s == 32'h83E7, "R11 clear alias", s, 32'h83E7);
        wr(5'h08, 16'h0018); rd(5'h00, s);
        check(s == 32'h83E7, "R7 status bits not writable", s, 32'h83E7);
        wr(5'h0C, 16'h0003); rd(5'h00, s);
        check(s == 32'h83E4, "R11 invert alias", s, 32'h83E4);
        rd(5'h14, s);
        check(s == 0, "R11 unmapped read", s, 0);
        wr(5'h00, 16'h0000);

        // R1 rising edges, rate 0
        irq_cnt = 0;
        wr(5'h00, 16'h8003);
        pulses(3); idle(2);
        check(irq_cnt == 3, "R5 every capture irq", irq_cnt, 3);
        rd(5'h00, s);
        check(s[3] == 1'b1, "R7 not-empty flag", s, s | 32'h8);
        rd(5'h10, v); got.push_back(v);
        rd(5'h10, v); got.push_back(v);
        rd(5'h10, v); got.push_back(v);
        check(got[1] - got[0] == 4 && got[2] - got[1] == 4, "R1 rising spacing",
              got[1] - got[0], 4);
        check(got[2] == {16'h0, rise_tick}, "R8 16-bit tmr_a stamp", got[2], {16'h0, rise_tick});
        rd(5'h10, v);
        check(v == got[2], "R6 empty read repeats last", v, got[2]);
        rd(5'h00, s);
        check(s[3] == 1'b0, "R6 empty read leaves buffer empty", s, s & ~32'h8);
        wr(5'h00, 16'h0000);

        // R1 falling edges
        wr(5'h00, 16'h8002); pulses(2); drain(got);
        check(got.size() == 2, "R1 falling count", got.size(), 2);
        check(got.size() == 2 && got[1] - got[0] == 4, "R1 falling spacing", got.size(), 2);
        wr(5'h00, 16'h0000);

        // R1 every edge
        wr(5'h00, 16'h8001); pulses(2); drain(got);
        check(got.size() == 4, "R1 both-edge count", got.size(), 4);
        check(got.size() == 4 && got[1] - got[0] == 2 && got[3] - got[2] == 2,
              "R1 both-edge spacing", got.size(), 4);
        wr(5'h00, 16'h0000);

        // R2 divide by 4 and 16
        wr(5'h00, 16'h8004); pulses(8); drain(got);
        check(got.size() == 2, "R2 div4 count", got.size(), 2);
        check(got.size() == 2 && got[1] - got[0] == 16, "R2 div4 spacing", got.size(), 2);
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'h8005); pulses(15); drain(got);
        check(got.size() == 0, "R2 div16 no capture before 16th", got.size(), 0);
        pulses(1); drain(got);
        check(got.size() == 1 && got[0] == {16'h0, rise_tick}, "R2 div16 on 16th rise",
              got.size(), 1);
        wr(5'h00, 16'h0000);

        // R3 first-edge modes
        wr(5'h00, 16'h8006); pulses(2); drain(got);
        check(got.size() == 3, "R3 first falling then every edge", got.size(), 3);
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'h8206); pulses(2); drain(got);
        check(got.size() == 4, "R3 first rising then every edge", got.size(), 4);
        wr(5'h00, 16'h0000);

        // R4 interrupt-only
        irq_cnt = 0;
        wr(5'h00, 16'h8067); pulses(3); idle(2);
        check(irq_cnt == 3, "R4 irq per rise", irq_cnt, 3);
        rd(5'h00, s);
        check(s[3] == 1'b0, "R4 no capture stored", s, s & ~32'h8);
        wr(5'h00, 16'h0000);

        // R5 every 3rd capture, and R7 overflow
        irq_cnt = 0;
        wr(5'h00, 16'h8043); pulses(6); idle(2);
        check(irq_cnt == 2, "R5 every 3rd capture", irq_cnt, 2);
        rd(5'h00, s);
        check(s[4] == 1'b1 && s[3] == 1'b1, "R7 overflow flag", s, s | 32'h18);
        drain(got);
        check(got.size() == 4 && got[3] - got[0] == 12, "R7 oldest four kept", got.size(), 4);
        rd(5'h00, s);
        check(s[4] == 1'b1, "R7 overflow sticky after drain", s, s | 32'h10);
        wr(5'h00, 16'h8000); rd(5'h00, s);
        check(s == 32'h8000, "R10 mode 0 clears status", s, 32'h8000);

        // R8 timer select and 32-bit stamp
        wr(5'h00, 16'h8083); pulses(1); rd(5'h10, v);
        check(v == {16'h0, rise_tick ^ 16'h5A5A}, "R8 tmr_b select", v, {16'h0, rise_tick ^ 16'h5A5A});
        wr(5'h00, 16'h0000);
        wr(5'h00, 16'h8103); pulses(1); rd(5'h10, v);
        check(v == {rise_tick ^ 16'h5A5A, rise_tick}, "R8 wide stamp", v,
              {rise_tick ^ 16'h5A5A, rise_tick});
        wr(5'h00, 16'h0000);

        // R9 freeze and disable
        freeze_in = 1;
        wr(5'h00, 16'hC003); pulses(2); rd(5'h00, s);
        check(s[3] == 1'b0, "R9 frozen ignores edges", s, s & ~32'h8);
        freeze_in = 0; pulses(1); rd(5'h00, s);
        check(s[3] == 1'b1, "R9 capture resumes after freeze", s, s | 32'h8);
        wr(5'h04, 16'h8000); pulses(2); rd(5'h00, s);
        check(s == 32'h4003, "R10 disable clears buffer", s, 32'h4003);
        freeze_in = 1;
        wr(5'h00, 16'h8003); pulses(1); rd(5'h00, s);
        check(s[3] == 1'b1, "R9 freeze ignored without bit 14", s, s | 32'h8);
        freeze_in = 0;
        wr(5'h00, 16'h0000);

        idle(3);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule